// File: doc/BRIEF.md
# Command Packet Descriptor Parser

This block reads one channel's command packet from memory and turns it into a stream of transfer requests. A one-cycle run strobe starts it. The block then fetches the 64-byte control area, word by word, from a synchronous 32-bit read port, starting at the programmed base address. It decodes the host control block, the device control block and the first word of the embedded register FIS. Before it issues any request, it checks that the packet is well formed: the sub-block headers, the valid flag, the self-referencing table pointer, and the entry count.

If the checks pass, the block walks the scatter-gather table that sits directly after the control area. For each 16-byte entry it presents one address/length request on a valid/ready interface. It adds up the granted lengths, and at completion it compares the sum with the byte total declared in the packet. A one-cycle completion pulse ends every run, whether or not the packet was malformed. The decoded flags and the error indications stay readable until the next run.

Top module: `cmd_pkt_parser`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `xfer_valid`, `mem_rd`, `fmt_err` and `len_err` are all low.
- R2: The control area is fetched from the base address that was sampled with `run_pkt`. The decoded outputs follow these fields:
  - byte 1 bit 0 drives `dir_out` and bit 4 drives `irq_en`;
  - byte 28 bit 2 drives `pio_dma` and bit 3 drives `lba48`;
  - bytes 32..35 drive `fis_word`.
- R3: A packet is a format error, with `fmt_err` set and no request issued, in any of these cases:
  - byte 0 is not 0x01;
  - byte 24 is not 0x02;
  - the valid flag (byte 1 bit 5) is clear.
- R4: The 64-bit little-endian table pointer at bytes 16..23 must equal base+64. Otherwise the packet is a format error with no request.
- R5: The entry count sits at bytes 8..11. A count of zero with the data flag set (byte 1 bit 3) is a format error. A count of zero with the data flag clear completes with no request.
- R6: An entry count larger than the MAX_PRD parameter is a format error with no request.
- R7: Entry i sits at base+64+16*i. It yields one request whose `xfer_addr` is the little-endian 64-bit value at entry bytes 0..7 and whose `xfer_len` is the 32-bit value at bytes 8..11. Requests come in table order, and `xfer_last` is set only on the final one.
- R8: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_addr` and `xfer_len` hold.
- R9: At completion, `len_err` is set when the sum of the granted lengths differs from the 32-bit total at bytes 4..7.
- R10: `done` is high for exactly one cycle per run, and `busy` is low in the cycle after it. A `run_pkt` strobe while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_pkt | input | 1 | One-cycle start strobe |
| base_addr | input | AW | Byte address of the packet, sampled at start |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the word to read |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 64 | Buffer address of the request |
| xfer_len | output | 32 | Byte length of the request |
| xfer_last | output | 1 | Final request of the packet |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Packet failed the format checks |
| len_err | output | 1 | Sum of lengths differs from the declared total |
| dir_out | output | 1 | Decoded direction-out flag |
| irq_en | output | 1 | Decoded interrupt-enable flag |
| lba48 | output | 1 | Decoded 48-bit addressing flag |
| pio_dma | output | 1 | Decoded PIO-or-DMA flag |
| fis_word | output | 32 | First word of the register FIS |

## Verification
Some internal faults show up at once on the request channel. A wrong entry index or word counter produces a request whose address or length does not match the scoreboard, and that is visible on the first handshake after the fault. A wrong header capture or check shows up only at the completion pulse, through `fmt_err` or the decoded flags, or earlier as a request that should never have appeared. A stuck or mis-cleared length accumulator is seen only at the end of the run, when `len_err` is compared. A state machine that fails to ignore a second strobe appears as extra requests some dozens of cycles after the first run ends.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int unsigned CB_BYTES  = 64;
    localparam int unsigned HDR_WORDS = 9;
    localparam logic [7:0]  HCB_MAGIC = 8'h01;
    localparam logic [7:0]  DCB_MAGIC = 8'h02;

    localparam int HF_DIR     = 0;
    localparam int HF_DATA    = 3;
    localparam int HF_IEN     = 4;
    localparam int HF_VALID   = 5;
    localparam int DF_PIO_DMA = 2;
    localparam int DF_LBA48   = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HRD, ST_HCAP, ST_HCHK, ST_PRD, ST_PCAP, ST_EMIT, ST_DONE
    } cpd_state_e;

    typedef struct packed {
        logic [7:0]  hcb_hdr;
        logic [7:0]  hflags;
        logic [31:0] total;
        logic [31:0] count;
        logic [63:0] prd_ptr;
        logic [7:0]  dcb_hdr;
        logic [7:0]  dflags;
        logic [31:0] fis_w0;
    } cpd_hdr_t;

    typedef struct packed {
        logic bad_hcb;
        logic not_valid;
        logic bad_dcb;
        logic bad_ptr;
        logic empty_data;
        logic too_many;
    } cpd_err_t;

    function automatic logic [7:0] lane(input logic [31:0] w, input logic [1:0] b);
        return w[8*b +: 8];
    endfunction

    function automatic logic has_err(input cpd_err_t e);
        return |e;
    endfunction

endpackage

// File: rtl/cpd_hdr_check.sv
module cpd_hdr_check
    import cpd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_PRD = 128
) (
    input  cpd_hdr_t        hdr,
    input  logic [AW-1:0]   base,
    output cpd_err_t        err
);
    logic [63:0] ptr_exp;

    always_comb begin
        ptr_exp        = 64'(base) + 64'(CB_BYTES);
        err.bad_hcb    = (hdr.hcb_hdr != HCB_MAGIC);
        err.not_valid  = !hdr.hflags[HF_VALID];
        err.bad_dcb    = (hdr.dcb_hdr != DCB_MAGIC);
        err.bad_ptr    = (hdr.prd_ptr != ptr_exp);
        err.empty_data = (hdr.count == 32'd0) && hdr.hflags[HF_DATA];
        err.too_many   = (hdr.count > 32'(MAX_PRD));
    end
endmodule

// File: rtl/cpd_len_acc.sv
module cpd_len_acc #(
    parameter int SW = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        add,
    input  logic [31:0] len,
    input  logic [31:0] total,
    output logic        mism,
    output logic        mism_add
);
    logic [SW-1:0] sum_q;
    logic [SW-1:0] sum_nx;

    always_comb begin
        sum_nx   = sum_q + SW'(len);
        mism     = (sum_q  != SW'(total));
        mism_add = (sum_nx != SW'(total));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) sum_q <= '0;
        else if (add)   sum_q <= sum_nx;
    end

    // R9: a cleared accumulator starts the next packet from zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum_q == '0));
endmodule

// File: rtl/cpd_xfer_slot.sv
module cpd_xfer_slot (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [63:0] addr_in,
    input  logic [31:0] len_in,
    input  logic        last_in,
    input  logic        ready,
    output logic        valid,
    output logic [63:0] addr,
    output logic [31:0] len,
    output logic        last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            len   <= '0;
            last  <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= addr_in;
            len   <= len_in;
            last  <= last_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R8: an unaccepted request stays put
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(len)));
endmodule

// File: rtl/cmd_pkt_parser.sv
module cmd_pkt_parser
    import cpd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_PRD = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_pkt,
    input  logic [AW-1:0] base_addr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic          xfer_valid,
    input  logic          xfer_ready,
    output logic [63:0]   xfer_addr,
    output logic [31:0]   xfer_len,
    output logic          xfer_last,
    output logic          busy,
    output logic          done,
    output logic          fmt_err,
    output logic          len_err,
    output logic          dir_out,
    output logic          irq_en,
    output logic          lba48,
    output logic          pio_dma,
    output logic [31:0]   fis_word
);
    localparam int PW = $clog2(MAX_PRD + 1);
    localparam int SW = 32 + PW;

    cpd_state_e    state;
    logic [3:0]    hw;
    logic [1:0]    widx;
    logic [PW-1:0] pidx;
    logic [AW-1:0] base_q;
    logic [31:0]   prd_lo, prd_hi;
    logic          fmt_q, len_q;
    cpd_hdr_t      hdr_q;
    cpd_err_t      err;
    logic          mism, mism_add;
    logic          last_entry, fire, slot_load, acc_clr;
    logic [AW-1:0] hdr_addr, prd_addr;

    cpd_hdr_check #(.AW(AW), .MAX_PRD(MAX_PRD)) u_check (
        .hdr (hdr_q),
        .base(base_q),
        .err (err)
    );

    always_comb begin
        last_entry = (32'(pidx) == (hdr_q.count - 32'd1));
        fire       = (state == ST_EMIT) && xfer_valid && xfer_ready;
        slot_load  = (state == ST_PCAP) && (widx == 2'd2);
        acc_clr    = (state == ST_IDLE) && run_pkt;
        hdr_addr   = base_q + AW'({hw, 2'b00});
        prd_addr   = base_q + AW'(CB_BYTES) + AW'({pidx, 4'b0000}) + AW'({widx, 2'b00});
        mem_rd     = (state == ST_HRD) || (state == ST_PRD);
        mem_addr   = (state == ST_HRD) ? hdr_addr : prd_addr;
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        fmt_err    = fmt_q;
        len_err    = len_q;
        dir_out    = hdr_q.hflags[HF_DIR];
        irq_en     = hdr_q.hflags[HF_IEN];
        lba48      = hdr_q.dflags[DF_LBA48];
        pio_dma    = hdr_q.dflags[DF_PIO_DMA];
        fis_word   = hdr_q.fis_w0;
    end

    cpd_len_acc #(.SW(SW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (acc_clr),
        .add     (fire),
        .len     (xfer_len),
        .total   (hdr_q.total),
        .mism    (mism),
        .mism_add(mism_add)
    );

    cpd_xfer_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .load   (slot_load),
        .addr_in({prd_hi, prd_lo}),
        .len_in (mem_rdata),
        .last_in(last_entry),
        .ready  (xfer_ready),
        .valid  (xfer_valid),
        .addr   (xfer_addr),
        .len    (xfer_len),
        .last   (xfer_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hw     <= '0;
            widx   <= '0;
            pidx   <= '0;
            base_q <= '0;
            prd_lo <= '0;
            prd_hi <= '0;
            fmt_q  <= 1'b0;
            len_q  <= 1'b0;
            hdr_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (run_pkt) begin
                    base_q <= base_addr;
                    hw     <= '0;
                    fmt_q  <= 1'b0;
                    len_q  <= 1'b0;
                    state  <= ST_HRD;
                end
                ST_HRD: state <= ST_HCAP;
                ST_HCAP: begin
                    case (hw)
                        4'd0: begin
                            hdr_q.hcb_hdr <= lane(mem_rdata, 2'd0);
                            hdr_q.hflags  <= lane(mem_rdata, 2'd1);
                        end
                        4'd1: hdr_q.total          <= mem_rdata;
                        4'd2: hdr_q.count          <= mem_rdata;
                        4'd4: hdr_q.prd_ptr[31:0]  <= mem_rdata;
                        4'd5: hdr_q.prd_ptr[63:32] <= mem_rdata;
                        4'd6: hdr_q.dcb_hdr        <= lane(mem_rdata, 2'd0);
                        4'd7: hdr_q.dflags         <= lane(mem_rdata, 2'd0);
                        4'd8: hdr_q.fis_w0         <= mem_rdata;
                        default: ;
                    endcase
                    if (hw == 4'(HDR_WORDS - 1)) begin
                        state <= ST_HCHK;
                    end else begin
                        hw    <= hw + 4'd1;
                        state <= ST_HRD;
                    end
                end
                ST_HCHK: begin
                    if (has_err(err)) begin
                        fmt_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (hdr_q.count == 32'd0) begin
                        len_q <= mism;
                        state <= ST_DONE;
                    end else begin
                        pidx  <= '0;
                        widx  <= '0;
                        state <= ST_PRD;
                    end
                end
                ST_PRD: state <= ST_PCAP;
                ST_PCAP: begin
                    case (widx)
                        2'd0: begin prd_lo <= mem_rdata; widx <= 2'd1; state <= ST_PRD; end
                        2'd1: begin prd_hi <= mem_rdata; widx <= 2'd2; state <= ST_PRD; end
                        default: state <= ST_EMIT;
                    endcase
                end
                ST_EMIT: if (fire) begin
                    if (last_entry) begin
                        len_q <= mism_add;
                        state <= ST_DONE;
                    end else begin
                        pidx  <= pidx + PW'(1);
                        widx  <= '0;
                        state <= ST_PRD;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse that returns the block to idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R10: a strobe during a run does not end or restart it
    a_r10_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && run_pkt) |=> busy);
    // R3: a malformed packet never produces a request
    a_r3_no_xfer_on_fmt: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> !xfer_valid);
    // R1: an idle block is quiet on both interfaces
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !xfer_valid));
endmodule

// File: tb/test_cmd_pkt_parser.sv
module test_cmd_pkt_parser;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_pkt = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          xfer_valid;
    logic          xfer_ready = 1'b0;
    logic [63:0]   xfer_addr;
    logic [31:0]   xfer_len;
    logic          xfer_last;
    logic          busy, done, fmt_err, len_err;
    logic          dir_out, irq_en, lba48, pio_dma;
    logic [31:0]   fis_word;

    always #10 clk = ~clk;

    cmd_pkt_parser #(.AW(AW), .MAX_PRD(128)) i_cmd_pkt_parser (
        .clk(clk), .rst(rst), .run_pkt(run_pkt), .base_addr(base_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_last(xfer_last),
        .busy(busy), .done(done), .fmt_err(fmt_err), .len_err(len_err),
        .dir_out(dir_out), .irq_en(irq_en), .lba48(lba48), .pio_dma(pio_dma),
        .fis_word(fis_word)
    );

    logic [31:0] mem [0:511];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];

    typedef struct packed {
        logic [63:0] a;
        logic [31:0] l;
        logic        last;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: set ready for the coming edge, then score any handshake
    always @(negedge clk) begin
        cyc++;
        xfer_ready = ((cyc % 4) != 1);
        if (!rst && xfer_valid && xfer_ready) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected request", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R7 addr", xfer_addr, e.a);
                check("R7 len", 64'(xfer_len), 64'(e.l));
                check("R7 last", 64'(xfer_last), 64'(e.last));
            end
        end
    end

    task automatic put_pkt(input int base, input logic [7:0] hcb, input logic [7:0] hfl,
                           input logic [7:0] dcb, input logic [7:0] dfl,
                           input logic [31:0] total, input logic [31:0] count,
                           input logic [63:0] ptr, input logic [31:0] fis);
        int w;
        w = base >> 2;
        mem[w+0] = {16'h0, hfl, hcb};
        mem[w+1] = total;
        mem[w+2] = count;
        mem[w+3] = 32'h0;
        mem[w+4] = ptr[31:0];
        mem[w+5] = ptr[63:32];
        mem[w+6] = {24'h0, dcb};
        mem[w+7] = {24'h0, dfl};
        mem[w+8] = fis;
    endtask

    task automatic put_prd(input int base, input int i, input logic [63:0] a,
                           input logic [31:0] l, input bit push, input bit last);
        int w;
        w = (base + 64 + 16*i) >> 2;
        mem[w+0] = a[31:0];
        mem[w+1] = a[63:32];
        mem[w+2] = l;
        mem[w+3] = 32'hDEAD_BEEF;
        if (push) exp_q.push_back('{a: a, l: l, last: last});
    endtask

    task automatic start(input int base);
        @(negedge clk);
        base_addr = AW'(base);
        run_pkt   = 1'b1;
        @(negedge clk);
        run_pkt   = 1'b0;
    endtask

    task automatic finish_run(input string req, input bit exp_fmt, input bit exp_len);
        while (!done) @(negedge clk);
        check({req, " fmt_err"}, 64'(fmt_err), 64'(exp_fmt));
        check({req, " len_err"}, 64'(len_err), 64'(exp_len));
        check({req, " all requests seen"}, 64'(exp_q.size()), 0);
        @(negedge clk);
        check("R10 done single cycle", 64'({done, busy}), 0);
    endtask

    task automatic load_good_a;
        put_pkt(32'h100, 8'h01, 8'h39, 8'h02, 8'h0C, 32'h1230, 32'd3, 64'h140, 32'h0035_8027);
    endtask

    task automatic prds_a(input bit push);
        put_prd(32'h100, 0, 64'h0000_0001_0000_0000, 32'h200,  push, 0);
        put_prd(32'h100, 1, 64'h0000_0000_8000_4000, 32'h1000, push, 0);
        put_prd(32'h100, 2, 64'hABCD_0000_1234_5670, 32'h30,   push, 1);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset outputs", 64'({busy, done, xfer_valid, mem_rd, fmt_err, len_err}), 0);

        // R2 R7 well-formed packet with three entries
        load_good_a();
        prds_a(1);
        start(32'h100);
        finish_run("R7 good packet", 0, 0);
        check("R2 dir_out",  64'(dir_out), 1);
        check("R2 irq_en",   64'(irq_en), 1);
        check("R2 lba48",    64'(lba48), 1);
        check("R2 pio_dma",  64'(pio_dma), 1);
        check("R2 fis_word", 64'(fis_word), 64'h0035_8027);

        // R9 length mismatch at another base, read direction
        put_pkt(32'h400, 8'h01, 8'h28, 8'h02, 8'h04, 32'h900, 32'd2, 64'h440, 32'h0025_8027);
        put_prd(32'h400, 0, 64'h0000_0001_2345_6000, 32'h800, 1, 0);
        put_prd(32'h400, 1, 64'hFFFF_0000_0000_1000, 32'h10,  1, 1);
        start(32'h400);
        finish_run("R9 sum mismatch", 0, 1);
        check("R2 dir_out read", 64'(dir_out), 0);
        check("R2 lba48 clear",  64'(lba48), 0);

        // R3 valid flag clear
        put_pkt(32'h100, 8'h01, 8'h19, 8'h02, 8'h0C, 32'h1230, 32'd3, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R3 valid clear", 1, 0);

        // R3 wrong host header
        put_pkt(32'h100, 8'h03, 8'h39, 8'h02, 8'h0C, 32'h1230, 32'd3, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R3 bad host header", 1, 0);

        // R3 wrong device header
        put_pkt(32'h100, 8'h01, 8'h39, 8'h00, 8'h0C, 32'h1230, 32'd3, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R3 bad device header", 1, 0);

        // R4 table pointer not at base+64
        put_pkt(32'h100, 8'h01, 8'h39, 8'h02, 8'h0C, 32'h1230, 32'd3, 64'h150, 32'h0);
        start(32'h100);
        finish_run("R4 bad pointer", 1, 0);
        put_pkt(32'h100, 8'h01, 8'h39, 8'h02, 8'h0C, 32'h1230, 32'd3, 64'h1_0000_0140, 32'h0);
        start(32'h100);
        finish_run("R4 pointer upper word", 1, 0);

        // R5 zero count with data flag
        put_pkt(32'h100, 8'h01, 8'h38, 8'h02, 8'h0C, 32'h0, 32'd0, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R5 empty data packet", 1, 0);

        // R5 zero count, no data flag, zero total
        put_pkt(32'h100, 8'h01, 8'h30, 8'h02, 8'h0C, 32'h0, 32'd0, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R5 non-data packet", 0, 0);

        // R9 zero count but nonzero total
        put_pkt(32'h100, 8'h01, 8'h30, 8'h02, 8'h0C, 32'h10, 32'd0, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R9 zero entries nonzero total", 0, 1);

        // R6 too many entries
        put_pkt(32'h100, 8'h01, 8'h39, 8'h02, 8'h0C, 32'h1230, 32'd129, 64'h140, 32'h0);
        start(32'h100);
        finish_run("R6 count above limit", 1, 0);

        // R10 strobe while busy ignored; base changes mid-run are not seen
        load_good_a();
        prds_a(1);
        put_pkt(32'h400, 8'h01, 8'h28, 8'h02, 8'h04, 32'h810, 32'd2, 64'h440, 32'h0);
        start(32'h100);
        repeat (4) @(negedge clk);
        base_addr = AW'(32'h400);
        run_pkt   = 1'b1;
        @(negedge clk);
        run_pkt   = 1'b0;
        finish_run("R10 second strobe ignored", 0, 0);
        repeat (40) @(negedge clk);
        check("R10 stays idle", 64'(busy), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule